// File: doc/BRIEF.md
# Interrupt-Triggered Data Transfer Controller

This block lets selected interrupt sources move data without involving the CPU. Every source has a pending flag, a priority and a transfer-enable input. A pending source is accepted only when its priority is strictly above the CPU's current mask level. If its transfer-enable input is high, the source starts a small transfer engine. Otherwise the source goes straight to the CPU as an ordinary interrupt request.

Each start moves one unit only. The engine first reads a pointer from a per-source vector table. It then reads a four-word descriptor from that pointer: mode, source address, destination address and count. Next it reads one byte or one word, writes that unit to the destination, and writes the updated addresses and count back to the descriptor. Only when the count reaches zero does the engine raise a CPU interrupt for that source. Software re-arms the transfer by rewriting the descriptor. The memory side is a single-port master with a request and ready handshake.

Top module: `itrx_top`

## Requirements
- R1: A pending source is accepted only if its priority is strictly greater than `cpu_mask`. A masked request stays pending and is accepted once the mask drops below its priority. Acceptance takes two cycles: one cycle selects the winner and the next confirms it.
- R2: When several eligible sources are pending, the one with the highest priority is accepted first. Equal priorities go to the lowest source index.
- R3: An accepted source with `xfer_en` high starts the engine, and no CPU interrupt is raised unless that unit is its last. An accepted source with `xfer_en` low sets its `cpu_irq` bit and causes no memory access.
- R4: The engine reads the descriptor pointer from address `VEC_BASE + 2*index`. The descriptor words follow that pointer at byte offsets +0 (mode), +2 (source), +4 (destination) and +6 (count).
- R5: Mode bit 0 selects the unit size: 1 moves a full 16-bit word, and 0 moves one byte. A byte is carried on data bits [7:0] with `mem_byte` high, and the memory lane is chosen by address bit 0 (0 means the low byte).
- R6: Mode bit 1 advances the source address after the move, and mode bit 2 advances the destination address. The step is 2 for a word and 1 for a byte. An address whose bit is clear is written back unchanged.
- R7: Each start moves exactly one unit and decrements the count by one. A count of 0 becomes 0xFFFF, which makes 65,536 units in total, and raises no interrupt.
- R8: When the written-back count is zero, `cpu_irq[index]` is set. A set `cpu_irq` bit stays set until a `cpu_ack` pulse on that bit clears it.
- R9: `mem_req` stays high with a stable address and write enable until `mem_ready` is seen. `mem_we` is only high together with `mem_req`. No request is made while the block is idle.
- R10: Accepting a source clears its pending flag, so one request pulse produces exactly one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Request pulses, one bit per source |
| irq_prio | input | NSRC*PW | Priority of each source, packed by index |
| xfer_en | input | NSRC | Route the source to the engine when high |
| cpu_mask | input | PW | CPU mask level |
| cpu_ack | input | NSRC | Clears the matching cpu_irq bit |
| cpu_irq | output | NSRC | Interrupt requests to the CPU |
| busy | output | 1 | Engine or arbiter active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_byte | output | 1 | Byte access on data bits [7:0] |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The hardest case to reach from the ports is a contest between sources. Two requests must become pending in the same cycle so that the arbiter sees both at once. The bench pulses both request bits in one cycle. It then inspects the descriptors in memory at the exact cycle the first transfer ends, before the second transfer has written anything. The wrap case is reached by presetting a zero count in the descriptor. The masked case is reached by firing a request while the mask equals its priority and lowering the mask afterwards.

// File: rtl/itrx_pkg.sv
package itrx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARB, S_VEC, S_DESC, S_DRD, S_DWR, S_WB
  } itrx_st_e;

  // mode word bit positions
  localparam int MODE_WORD = 0;
  localparam int MODE_SINC = 1;
  localparam int MODE_DINC = 2;

  // descriptor word slots
  localparam int SLOT_MODE = 0;
  localparam int SLOT_SRC  = 1;
  localparam int SLOT_DST  = 2;
  localparam int SLOT_CNT  = 3;
endpackage

// File: rtl/itrx_arb.sv
module itrx_arb #(
  parameter int NSRC = 4,
  parameter int PW   = 3,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic [PW-1:0]      cpu_mask,
  output logic               any,
  output logic [IW-1:0]      win_idx
);
  logic [PW-1:0] best;
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (prio_flat[i*PW +: PW] > cpu_mask) &&
          (!any || prio_flat[i*PW +: PW] > best)) begin
        any     = 1'b1;
        win_idx = IW'(i);
        best    = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/itrx_flags.sv
module itrx_flags #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] pend_clr,
  input  logic [NSRC-1:0] cpu_set,
  input  logic [NSRC-1:0] cpu_ack,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] cpu_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      cpu_irq <= '0;
    end else begin
      pend    <= (pend & ~pend_clr) | irq_req;
      cpu_irq <= (cpu_irq & ~cpu_ack) | cpu_set;
    end
  end
endmodule

// File: rtl/itrx_seq.sv
module itrx_seq
  import itrx_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int PW   = 3,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter logic [AW-1:0] VEC_BASE = '0,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int BPW = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_any,
  input  logic [IW-1:0]      arb_idx,
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic [PW-1:0]      cpu_mask,
  input  logic [NSRC-1:0]    xfer_en,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_byte,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_ready,
  output logic [NSRC-1:0]    pend_clr,
  output logic [NSRC-1:0]    cpu_set,
  output logic               busy,
  output logic               pick_fire,
  output logic               acc_fire,
  output logic               start_fire,
  output logic               done_fire,
  output logic [IW-1:0]      cur_idx
);
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic wide, input logic inc);
    logic [AW-1:0] d;
    d = wide ? AW'(BPW) : AW'(1);
    return inc ? a + d : a;
  endfunction

  function automatic logic [DW-1:0] dec_cnt(input logic [DW-1:0] c);
    return c - DW'(1);
  endfunction

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                              input logic [2:0] k);
    return base + AW'(k) * AW'(BPW);
  endfunction

  itrx_st_e      st;
  logic [1:0]    sub;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] ptr, src, dst;
  logic [DW-1:0] mode, cnt, dat;
  logic          hs, acc_ok, route_fire, wide;

  assign cur_idx    = idx_q;
  assign wide       = mode[MODE_WORD];
  assign busy       = (st != S_IDLE);
  assign mem_req    = st inside {S_VEC, S_DESC, S_DRD, S_DWR, S_WB};
  assign mem_we     = st inside {S_DWR, S_WB};
  assign mem_byte   = (st inside {S_DRD, S_DWR}) && !wide;
  assign hs         = mem_req && mem_ready;
  assign acc_ok     = pend[idx_q] && (prio_flat[idx_q*PW +: PW] > cpu_mask);
  assign pick_fire  = (st == S_IDLE) && arb_any;
  assign acc_fire   = (st == S_ARB) && acc_ok;
  assign start_fire = acc_fire && xfer_en[idx_q];
  assign route_fire = acc_fire && !xfer_en[idx_q];
  assign done_fire  = (st == S_WB) && hs && (sub == 2'd2) && (cnt == '0);
  assign pend_clr   = acc_fire ? (NSRC'(1) << idx_q) : '0;
  assign cpu_set    = (route_fire || done_fire) ? (NSRC'(1) << idx_q) : '0;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_VEC:  mem_addr = slot_addr(VEC_BASE, 3'(idx_q));
      S_DESC: mem_addr = slot_addr(ptr, {1'b0, sub});
      S_DRD:  mem_addr = src;
      S_DWR: begin
        mem_addr  = dst;
        mem_wdata = wide ? dat : {{(DW-8){1'b0}}, dat[7:0]};
      end
      S_WB: begin
        mem_addr  = slot_addr(ptr, 3'(sub) + 3'd1);
        mem_wdata = (sub == 2'd0) ? DW'(src) : (sub == 2'd1) ? DW'(dst) : cnt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sub <= '0; idx_q <= '0;
      ptr <= '0; src <= '0; dst <= '0; mode <= '0; cnt <= '0; dat <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (arb_any) begin idx_q <= arb_idx; st <= S_ARB; end
        S_ARB:  st <= start_fire ? S_VEC : S_IDLE;
        S_VEC:  if (hs) begin ptr <= AW'(mem_rdata); sub <= '0; st <= S_DESC; end
        S_DESC: if (hs) begin
          unique case (sub)
            2'(SLOT_MODE): mode <= mem_rdata;
            2'(SLOT_SRC):  src  <= AW'(mem_rdata);
            2'(SLOT_DST):  dst  <= AW'(mem_rdata);
            default:       cnt  <= mem_rdata;
          endcase
          if (sub == 2'(SLOT_CNT)) st <= S_DRD;
          else sub <= sub + 2'd1;
        end
        S_DRD:  if (hs) begin dat <= mem_rdata; st <= S_DWR; end
        S_DWR:  if (hs) begin
          src <= step_addr(src, wide, mode[MODE_SINC]);
          dst <= step_addr(dst, wide, mode[MODE_DINC]);
          cnt <= dec_cnt(cnt);
          sub <= '0;
          st  <= S_WB;
        end
        S_WB:   if (hs) begin
          if (sub == 2'd2) st <= S_IDLE;
          else sub <= sub + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itrx_top.sv
module itrx_top #(
  parameter int NSRC = 4,
  parameter int PW   = 3,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter logic [AW-1:0] VEC_BASE = '0,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_req,
  input  logic [NSRC*PW-1:0] irq_prio,
  input  logic [NSRC-1:0]    xfer_en,
  input  logic [PW-1:0]      cpu_mask,
  input  logic [NSRC-1:0]    cpu_ack,
  output logic [NSRC-1:0]    cpu_irq,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_byte,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_ready
);
  logic [NSRC-1:0] pend, pend_clr, cpu_set;
  logic            arb_any, pick_fire, acc_fire, start_fire, done_fire;
  logic [IW-1:0]   arb_idx, cur_idx;

  itrx_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pend_clr(pend_clr),
    .cpu_set(cpu_set), .cpu_ack(cpu_ack), .pend(pend), .cpu_irq(cpu_irq)
  );

  itrx_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
    .pend(pend), .prio_flat(irq_prio), .cpu_mask(cpu_mask),
    .any(arb_any), .win_idx(arb_idx)
  );

  itrx_seq #(.NSRC(NSRC), .PW(PW), .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .arb_any(arb_any), .arb_idx(arb_idx),
    .pend(pend), .prio_flat(irq_prio), .cpu_mask(cpu_mask), .xfer_en(xfer_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .pend_clr(pend_clr), .cpu_set(cpu_set),
    .busy(busy), .pick_fire(pick_fire), .acc_fire(acc_fire),
    .start_fire(start_fire), .done_fire(done_fire), .cur_idx(cur_idx)
  );
endmodule

// File: rtl/itrx_chk.sv
module itrx_chk #(
  parameter int NSRC = 4,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter logic [AW-1:0] VEC_BASE = '0,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [NSRC-1:0] cpu_irq,
  input logic [NSRC-1:0] cpu_ack,
  input logic [NSRC-1:0] pend_clr,
  input logic            pick_fire,
  input logic            acc_fire,
  input logic            start_fire,
  input logic            done_fire,
  input logic [IW-1:0]   cur_idx
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R9
  we_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R1
  two_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> $past(pick_fire));
  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));
  // R4
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> mem_req && !mem_we &&
      mem_addr == VEC_BASE + AW'($past(cur_idx)) * AW'(DW / 8));
  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> cpu_irq[$past(cur_idx)]);

  for (genvar i = 0; i < NSRC; i++) begin : g_hold
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[i] && !cpu_ack[i] |=> cpu_irq[i]);
  end
endmodule

bind itrx_top itrx_chk #(.NSRC(NSRC), .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .cpu_irq(cpu_irq),
  .cpu_ack(cpu_ack), .pend_clr(pend_clr), .pick_fire(pick_fire),
  .acc_fire(acc_fire), .start_fire(start_fire), .done_fire(done_fire),
  .cur_idx(cur_idx)
);

// File: tb/itrx_top_test.sv
`timescale 1ns/1ps
module itrx_top_test;
  localparam int NSRC = 4, PW = 3, AW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0, xfer_en = '0, cpu_ack = '0, cpu_irq;
  logic [NSRC*PW-1:0] irq_prio = '0;
  logic [PW-1:0] cpu_mask = '0;
  logic busy, mem_req, mem_we, mem_byte, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [15:0] mem [0:127];
  logic rdy = 1'b0;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  itrx_top uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
    .xfer_en(xfer_en), .cpu_mask(cpu_mask), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  // memory model: one wait cycle per access, little-endian byte lanes
  assign mem_ready = rdy;
  always @(posedge clk) rdy <= rst_n && mem_req && !rdy;
  assign mem_rdata = !mem_byte ? mem[mem_addr[7:1]] :
                     {8'h00, mem_addr[0] ? mem[mem_addr[7:1]][15:8] : mem[mem_addr[7:1]][7:0]};
  always @(posedge clk)
    if (mem_req && mem_we && rdy) begin
      if (!mem_byte) mem[mem_addr[7:1]] = mem_wdata;
      else if (mem_addr[0]) mem[mem_addr[7:1]][15:8] = mem_wdata[7:0];
      else mem[mem_addr[7:1]][7:0] = mem_wdata[7:0];
    end

  function automatic logic [15:0] dbase(int i);
    return 16'h20 + 16'(i) * 16'h10;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setw(logic [15:0] a, logic [15:0] v); mem[a[7:1]] = v; endtask

  task automatic setup(int i, logic [15:0] mode, logic [15:0] s, logic [15:0] d, logic [15:0] c);
    setw(16'(2 * i), dbase(i));
    setw(dbase(i), mode); setw(dbase(i) + 2, s); setw(dbase(i) + 4, d); setw(dbase(i) + 6, c);
  endtask

  task automatic fire(logic [NSRC-1:0] m);
    @(negedge clk) irq_req = m;
    @(negedge clk) irq_req = '0;
  endtask

  task automatic quiet();
    int q = 0;
    for (int n = 0; n < 2000 && q < 4; n++) begin
      @(negedge clk);
      q = (!busy && !mem_req) ? q + 1 : 0;
    end
  endtask

  task automatic first_done();
    for (int n = 0; n < 2000 && !busy; n++) @(negedge clk);
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic ack(int i);
    @(negedge clk) cpu_ack[i] = 1'b1;
    @(negedge clk) cpu_ack[i] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset mem_req", 32'(mem_req), 0);
    chk("R8 reset cpu_irq", 32'(cpu_irq), 0);
    chk("R9 reset busy", 32'(busy), 0);
  endtask

  task automatic t_word();
    irq_prio[0 +: 3] = 3'd5; xfer_en[0] = 1'b1;
    setw(16'h80, 16'hBEEF); setw(16'h82, 16'h1234);
    setw(16'hA0, 16'h0); setw(16'hA2, 16'h0);
    setup(0, 16'h7, 16'h80, 16'hA0, 16'd2);
    fire(4'b0001); quiet();
    chk("R5 word data", 32'(mem[8'hA0 >> 1]), 32'hBEEF);
    chk("R10 one unit only", 32'(mem[8'hA2 >> 1]), 0);
    chk("R6 src step 2", 32'(mem[(dbase(0) + 2) >> 1]), 32'h82);
    chk("R6 dst step 2", 32'(mem[(dbase(0) + 4) >> 1]), 32'hA2);
    chk("R7 count dec", 32'(mem[(dbase(0) + 6) >> 1]), 1);
    chk("R3 no cpu irq mid", 32'(cpu_irq), 0);
    fire(4'b0001); quiet();
    chk("R5 second word", 32'(mem[8'hA2 >> 1]), 32'h1234);
    chk("R7 count zero", 32'(mem[(dbase(0) + 6) >> 1]), 0);
    chk("R8 last raises irq", 32'(cpu_irq), 32'h1);
    repeat (5) @(negedge clk);
    chk("R8 irq held", 32'(cpu_irq), 32'h1);
    ack(0);
    chk("R8 ack clears", 32'(cpu_irq), 0);
  endtask

  task automatic t_byte();
    irq_prio[3 +: 3] = 3'd2; xfer_en[1] = 1'b1;
    setw(16'h84, 16'h5A77); setw(16'hB0, 16'h1111);
    setup(1, 16'h0, 16'h85, 16'hB0, 16'd3);
    fire(4'b0010); quiet();
    chk("R5 byte to low lane", 32'(mem[8'hB0 >> 1]), 32'h115A);
    chk("R6 src held", 32'(mem[(dbase(1) + 2) >> 1]), 32'h85);
    chk("R6 dst held", 32'(mem[(dbase(1) + 4) >> 1]), 32'hB0);
    setw(16'h88, 16'h77CC); setw(16'hB2, 16'h2222);
    setup(1, 16'h6, 16'h88, 16'hB3, 16'd3);
    fire(4'b0010); quiet();
    chk("R5 byte to high lane", 32'(mem[8'hB2 >> 1]), 32'hCC22);
    chk("R6 src step 1", 32'(mem[(dbase(1) + 2) >> 1]), 32'h89);
    chk("R6 dst step 1", 32'(mem[(dbase(1) + 4) >> 1]), 32'hB4);
  endtask

  task automatic t_wrap();
    irq_prio[6 +: 3] = 3'd3; xfer_en[2] = 1'b1;
    setup(2, 16'h1, 16'h80, 16'hC0, 16'd0);
    fire(4'b0100); quiet();
    chk("R7 zero wraps", 32'(mem[(dbase(2) + 6) >> 1]), 32'hFFFF);
    chk("R7 no irq on wrap", 32'(cpu_irq), 0);
    chk("R4 vector-led copy", 32'(mem[8'hC0 >> 1]), 32'hBEEF);
  endtask

  task automatic t_mask();
    irq_prio[9 +: 3] = 3'd2; xfer_en[3] = 1'b1; cpu_mask = 3'd2;
    setup(3, 16'h1, 16'h82, 16'hC4, 16'd9);
    fire(4'b1000); quiet();
    chk("R1 equal level blocked", 32'(mem[(dbase(3) + 6) >> 1]), 9);
    @(negedge clk) cpu_mask = 3'd1;
    quiet();
    chk("R1 accepted after unmask", 32'(mem[(dbase(3) + 6) >> 1]), 8);
    chk("R1 data moved", 32'(mem[8'hC4 >> 1]), 32'h1234);
    cpu_mask = 3'd0;
  endtask

  task automatic t_route();
    irq_prio[3 +: 3] = 3'd4; xfer_en[1] = 1'b0;
    setup(1, 16'h1, 16'h80, 16'hB0, 16'd5);
    fire(4'b0010); quiet();
    chk("R3 routed to cpu", 32'(cpu_irq), 32'h2);
    chk("R3 no transfer", 32'(mem[(dbase(1) + 6) >> 1]), 5);
    ack(1); xfer_en[1] = 1'b1;
  endtask

  task automatic t_prio();
    irq_prio[0 +: 3] = 3'd3; irq_prio[3 +: 3] = 3'd6;
    setup(0, 16'h1, 16'h80, 16'hD0, 16'd7);
    setup(1, 16'h1, 16'h80, 16'hD2, 16'd7);
    fire(4'b0011); first_done();
    chk("R2 higher prio first", 32'(mem[(dbase(1) + 6) >> 1]), 6);
    chk("R2 lower waits", 32'(mem[(dbase(0) + 6) >> 1]), 7);
    quiet();
    chk("R10 both served once", 32'(mem[(dbase(0) + 6) >> 1]), 6);
    irq_prio[6 +: 3] = 3'd4; irq_prio[9 +: 3] = 3'd4;
    setup(2, 16'h1, 16'h80, 16'hD4, 16'd4);
    setup(3, 16'h1, 16'h80, 16'hD6, 16'd4);
    fire(4'b1100); first_done();
    chk("R2 tie low index", 32'(mem[(dbase(2) + 6) >> 1]), 3);
    chk("R2 tie high waits", 32'(mem[(dbase(3) + 6) >> 1]), 4);
    quiet();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word();
    t_byte();
    t_wrap();
    t_mask();
    t_route();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule